// File: doc/BRIEF.md
# Interrupt Input Conditioner with Enable Mask

This block takes a vector of asynchronous interrupt request lines and turns each one into a clean pending bit. Every line passes through a two-stage synchronizer. Its polarity is then corrected, so the line reads as 1 when asserted. A per-line mode selects what the pending bit means. In level mode it is the corrected input. In edge mode it is a sticky latch that records a transition. An optional dual-edge mode lets either transition set the latch. An enable vector gates the pending vector onto the interrupt output, and a single flag reports whether any enabled interrupt is pending.

Software configures the block through 32-bit word registers on a simple strobe bus. It sees the enable vector only through a read-only view. It changes enables only by writing ones into a set register or a clear register. It controls edge latches through one command word. Bit 31 of that word picks set or clear, and the low bits carry the interrupt number. Reads use a two-state access sequencer with the states ST_IDLE and ST_RESP. A read strobe in either state moves it to ST_RESP for the next cycle, where the captured data is presented. With no read strobe it moves to ST_IDLE. Writes are taken at the clock edge where the strobe is seen and leave the sequencer state unchanged.

Top module: `irq_cond_top`

## Requirements
- R1: After reset the polarity, trigger, dual-edge and enable registers all read 0. `irq_out` and `irq_any` are 0, and `reg_rvalid` is 0.
- R2: In level mode (trigger bit 0), pending bit i equals the synchronized input when polarity bit i is 1, and its inverse when polarity bit i is 0. It is visible from the second clock edge after the input changes.
- R3: In edge mode (trigger bit 1) with dual-edge 0, a rising input transition sets the latch when polarity is 1, and a falling transition sets it when polarity is 0. The opposite transition does not set it. Once set, the pending bit stays 1 after the input returns.
- R4: In edge mode with dual-edge bit 1, both input transitions set the latch.
- R5: A write to the command word at offset 0x280 with bit 31 = 1 sets the edge latch of the interrupt numbered in bits [4:0]. With bit 31 = 0 it clears that latch. Bits 30:5 are ignored. In level mode the pending bit still follows the input.
- R6: A write to the set-enable register (offset 0x380) turns on each enable bit written as 1. Bits written as 0 are left unchanged.
- R7: A write to the clear-enable register (offset 0x300) turns off each enable bit written as 1. Bits written as 0 are left unchanged.
- R8: Reads of the write-only words (0x280, 0x300, 0x380) and of unmapped words return 0. Writes to the enable view (0x400) and the pending view (0x480) change nothing.
- R9: `irq_out` is the pending vector ANDed with the enable vector, and `irq_any` is 1 exactly when `irq_out` is nonzero.
- R10: A read strobe yields `reg_rvalid` = 1 on the following cycle, with `reg_rdata` holding the word's value. The polarity (0x100), trigger (0x180) and dual-edge (0x200) words read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Raw asynchronous interrupt lines |
| reg_valid | input | 1 | Access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read, qualified by reg_valid |
| reg_addr | input | 12 | Byte address of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rvalid is 1 |
| reg_rvalid | output | 1 | Read response strobe |
| irq_out | output | 32 | Pending and enabled interrupts |
| irq_any | output | 1 | OR of irq_out |

## Verification
The bench targets the transitions that an edge latch must and must not record. It uses a falling edge on an active-low line, the opposite edge that must be ignored, and a dual-edge line beside a single-edge neighbour. A design that decoded polarity backwards, or ignored the dual-edge bit, would show the wrong pending bits in those cases. The command word is driven with junk in its middle bits to catch decoding that uses too many bits. It is also used on a level-mode line to catch a latch leaking into level pending. Enable writes with zero bits, and writes to the read-only views, catch a design that stores the written word instead of merging it.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

    // Word offsets of the register file (byte addresses)
    localparam logic [15:0] OFS_POL     = 16'h0100;
    localparam logic [15:0] OFS_TRIG    = 16'h0180;
    localparam logic [15:0] OFS_DUAL    = 16'h0200;
    localparam logic [15:0] OFS_EDGECMD = 16'h0280;
    localparam logic [15:0] OFS_ENCLR   = 16'h0300;
    localparam logic [15:0] OFS_ENSET   = 16'h0380;
    localparam logic [15:0] OFS_ENVIEW  = 16'h0400;
    localparam logic [15:0] OFS_PNDVIEW = 16'h0480;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] dual,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] edge_q,
    output logic [N-1:0] pend
);
    logic [N-1:0] act;
    logic [N-1:0] act_d;
    logic [N-1:0] hw_evt;

    for (genvar i = 0; i < N; i++) begin : g_cell
        // polarity-corrected line: 1 means asserted
        assign act[i] = pol[i] ? sync_in[i] : ~sync_in[i];
        // edge event only counts in edge mode
        assign hw_evt[i] = trig[i] &
                           (dual[i] ? (act[i] ^ act_d[i])
                                    : (act[i] & ~act_d[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_d  <= '0;
            edge_q <= '0;
        end else begin
            act_d  <= act;
            // a hardware event in the same cycle as a software clear wins
            edge_q <= hw_evt | sw_set | (edge_q & ~sw_clr);
        end
    end

    assign pend = (trig & edge_q) | (~trig & act);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_cond_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N-1:0]      pend,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      trig_q,
    output logic [N-1:0]      dual_q,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      sw_set,
    output logic [N-1:0]      sw_clr
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int WA_W  = ADDR_W - 2;

    acc_state_e state_q, state_d;

    logic            wr_req, rd_req;
    logic [WA_W-1:0] waddr;
    logic            hit_pol, hit_trig, hit_dual, hit_cmd;
    logic            hit_clr, hit_set, hit_env, hit_pnd;
    logic [DATA_W-1:0] rd_mux;
    logic [IDX_W-1:0]  cmd_idx;
    logic              cmd_flag;

    assign wr_req = reg_valid &  reg_write;
    assign rd_req = reg_valid & ~reg_write;
    assign waddr  = reg_addr[ADDR_W-1:2];

    assign hit_pol  = (waddr == OFS_POL[ADDR_W-1:2]);
    assign hit_trig = (waddr == OFS_TRIG[ADDR_W-1:2]);
    assign hit_dual = (waddr == OFS_DUAL[ADDR_W-1:2]);
    assign hit_cmd  = (waddr == OFS_EDGECMD[ADDR_W-1:2]);
    assign hit_clr  = (waddr == OFS_ENCLR[ADDR_W-1:2]);
    assign hit_set  = (waddr == OFS_ENSET[ADDR_W-1:2]);
    assign hit_env  = (waddr == OFS_ENVIEW[ADDR_W-1:2]);
    assign hit_pnd  = (waddr == OFS_PNDVIEW[ADDR_W-1:2]);

    logic unused_bits;
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-2:IDX_W]};

    // ---------------- access sequencer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
        endcase
    end

    always_comb begin
        reg_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE: reg_rvalid = 1'b0;
            ST_RESP: reg_rvalid = 1'b1;
        endcase
    end

    // ---------------- read path ----------------
    always_comb begin
        rd_mux = '0;
        if (hit_pol)       rd_mux[N-1:0] = pol_q;
        else if (hit_trig) rd_mux[N-1:0] = trig_q;
        else if (hit_dual) rd_mux[N-1:0] = dual_q;
        else if (hit_env)  rd_mux[N-1:0] = en_q;
        else if (hit_pnd)  rd_mux[N-1:0] = pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_req) reg_rdata <= rd_mux;
    end

    // ---------------- configuration and enables ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            trig_q <= '0;
            dual_q <= '0;
            en_q   <= '0;
        end else if (wr_req) begin
            if (hit_pol)  pol_q  <= reg_wdata[N-1:0];
            if (hit_trig) trig_q <= reg_wdata[N-1:0];
            if (hit_dual) dual_q <= reg_wdata[N-1:0];
            if (hit_set)  en_q   <= en_q | reg_wdata[N-1:0];
            if (hit_clr)  en_q   <= en_q & ~reg_wdata[N-1:0];
        end
    end

    // ---------------- edge command decode ----------------
    assign cmd_idx  = reg_wdata[IDX_W-1:0];
    assign cmd_flag = reg_wdata[DATA_W-1];

    for (genvar i = 0; i < N; i++) begin : g_cmd
        logic sel;
        assign sel       = wr_req & hit_cmd & (cmd_idx == IDX_W'(i));
        assign sw_set[i] = sel &  cmd_flag;
        assign sw_clr[i] = sel & ~cmd_flag;
    end
endmodule

// File: rtl/irq_cond_top.sv
module irq_cond_top #(
    parameter int N_IRQ  = 32,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IRQ-1:0]  irq_in,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic [N_IRQ-1:0]  irq_out,
    output logic              irq_any
);
    logic [N_IRQ-1:0] sync_in;
    logic [N_IRQ-1:0] pol_q, trig_q, dual_q, en_q;
    logic [N_IRQ-1:0] sw_set, sw_clr;
    logic [N_IRQ-1:0] edge_q, pend;

    irq_sync #(.W(N_IRQ)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (sync_in)
    );

    irq_pend #(.N(N_IRQ)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .pol     (pol_q),
        .trig    (trig_q),
        .dual    (dual_q),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .edge_q  (edge_q),
        .pend    (pend)
    );

    irq_regfile #(.N(N_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .pend       (pend),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .pol_q      (pol_q),
        .trig_q     (trig_q),
        .dual_q     (dual_q),
        .en_q       (en_q),
        .sw_set     (sw_set),
        .sw_clr     (sw_clr)
    );

    assign irq_out = pend & en_q;
    assign irq_any = |irq_out;
endmodule

// File: rtl/irq_cond_sva.sv
module irq_cond_sva
    import irq_cond_pkg::*;
#(
    parameter int N      = 32,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_rvalid,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      edge_q,
    input logic [N-1:0]      irq_out
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic rd_s, set_s, clr_s, cmd_s;
    assign rd_s  = reg_valid & ~reg_write;
    assign set_s = reg_valid & reg_write &
                   (reg_addr[ADDR_W-1:2] == OFS_ENSET[ADDR_W-1:2]);
    assign clr_s = reg_valid & reg_write &
                   (reg_addr[ADDR_W-1:2] == OFS_ENCLR[ADDR_W-1:2]);
    assign cmd_s = reg_valid & reg_write &
                   (reg_addr[ADDR_W-1:2] == OFS_EDGECMD[ADDR_W-1:2]);

    AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_s |=> reg_rvalid); // R10

    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_s |=> !reg_rvalid); // R10

    AST_SET_EN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_s |=> ((en_q & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0]))); // R6

    AST_CLR_EN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> ((en_q & $past(reg_wdata[N-1:0])) == '0)); // R7

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_s || clr_s) |=> $stable(en_q)); // R8

    AST_EDGE_CMD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_s && reg_wdata[DATA_W-1]) |=> edge_q[$past(reg_wdata[IDX_W-1:0])]); // R5

    AST_CLR_GATES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_s |=> ((irq_out & $past(reg_wdata[N-1:0])) == '0)); // R9
endmodule

bind irq_cond_top irq_cond_sva #(.N(N_IRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_valid  (reg_valid),
    .reg_write  (reg_write),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .en_q       (en_q),
    .edge_q     (edge_q),
    .irq_out    (irq_out)
);

// File: tb/irq_cond_top_tb_top.sv
module irq_cond_top_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [11:0] A_POL  = 12'h100;
    localparam logic [11:0] A_TRIG = 12'h180;
    localparam logic [11:0] A_DUAL = 12'h200;
    localparam logic [11:0] A_CMD  = 12'h280;
    localparam logic [11:0] A_CLR  = 12'h300;
    localparam logic [11:0] A_SET  = 12'h380;
    localparam logic [11:0] A_ENV  = 12'h400;
    localparam logic [11:0] A_PND  = 12'h480;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [31:0] irq_out;
    logic        irq_any;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cond_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .reg_valid  (reg_valid),
        .reg_write  (reg_write),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq_out    (irq_out),
        .irq_any    (irq_any)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        chk_eq("R10 rvalid after read", {31'b0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic cmd(input bit set, input int idx);
        wr(A_CMD, {set, 26'b0, 5'(idx)});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk_eq("R1 rvalid idle", {31'b0, reg_rvalid}, 32'd0);
        chk_eq("R1 irq_out", irq_out, 32'd0);
        chk_eq("R1 irq_any", {31'b0, irq_any}, 32'd0);
        rd(A_POL, v);  chk_eq("R1 polarity", v, 32'd0);
        rd(A_TRIG, v); chk_eq("R1 trigger", v, 32'd0);
        rd(A_DUAL, v); chk_eq("R1 dual", v, 32'd0);
        rd(A_ENV, v);  chk_eq("R1 enable", v, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        logic [31:0] p;
        p = 32'h0000_F00F;
        wr(A_POL, p);
        rd(A_POL, v); chk_eq("R10 polarity readback", v, p);
        irq_in = 32'h0000_3005;
        wait_n(3);
        rd(A_PND, v); chk_eq("R2 level pattern A", v, ~(irq_in ^ p));
        irq_in = 32'hA5A5_C00A;
        wait_n(3);
        rd(A_PND, v); chk_eq("R2 level pattern B", v, ~(irq_in ^ p));
    endtask

    task automatic t_edge();
        logic [31:0] v;
        wr(A_TRIG, 32'h0);
        wr(A_DUAL, 32'h0);
        wr(A_POL, 32'h1);
        irq_in = 32'h2;
        wait_n(4);
        wr(A_TRIG, 32'h3);
        rd(A_TRIG, v); chk_eq("R10 trigger readback", v, 32'h3);
        cmd(1'b0, 0); cmd(1'b0, 1);
        rd(A_PND, v); chk_eq("R3 edge idle", v & 32'h3, 32'h0);
        irq_in = 32'h3; wait_n(2);
        irq_in = 32'h2; wait_n(4);
        rd(A_PND, v); chk_eq("R3 rising latched and held", v & 32'h3, 32'h1);
        irq_in = 32'h0; wait_n(4);
        rd(A_PND, v); chk_eq("R3 falling on active-low latched", v & 32'h3, 32'h3);
        cmd(1'b0, 0); cmd(1'b0, 1);
        irq_in = 32'h2; wait_n(4);
        rd(A_PND, v); chk_eq("R3 opposite edge ignored", v & 32'h3, 32'h0);
    endtask

    task automatic t_dual();
        logic [31:0] v;
        wr(A_TRIG, 32'h0);
        wr(A_POL, 32'h30);
        wr(A_DUAL, 32'h10);
        rd(A_DUAL, v); chk_eq("R10 dual readback", v, 32'h10);
        irq_in = 32'h0;
        wait_n(4);
        wr(A_TRIG, 32'h30);
        cmd(1'b0, 4); cmd(1'b0, 5);
        irq_in = 32'h30; wait_n(4);
        rd(A_PND, v); chk_eq("R4 rise latches both", v & 32'h30, 32'h30);
        cmd(1'b0, 4); cmd(1'b0, 5);
        irq_in = 32'h0; wait_n(4);
        rd(A_PND, v); chk_eq("R4 fall latches dual only", v & 32'h30, 32'h10);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(A_TRIG, 32'h0);
        wr(A_DUAL, 32'h0);
        wr(A_POL, 32'h0);
        irq_in = 32'hFFFF_FFFF;
        wait_n(4);
        wr(A_TRIG, 32'h200);
        cmd(1'b0, 9);
        rd(A_PND, v); chk_eq("R5 cleared start", v, 32'h0);
        wr(A_CMD, 32'h8000_0009);
        rd(A_PND, v); chk_eq("R5 set by command", v, 32'h200);
        wr(A_CMD, 32'h7FFF_FFE9);
        rd(A_PND, v); chk_eq("R5 clear with junk bits", v, 32'h0);
        cmd(1'b1, 3);
        rd(A_PND, v); chk_eq("R5 level line follows input", v, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(A_SET, 32'h0000_00F0);
        rd(A_ENV, v); chk_eq("R6 set bits", v, 32'hF0);
        wr(A_SET, 32'h0);
        rd(A_ENV, v); chk_eq("R6 zero write keeps", v, 32'hF0);
        wr(A_CLR, 32'h0000_0030);
        rd(A_ENV, v); chk_eq("R7 clear bits", v, 32'hC0);
        wr(A_CLR, 32'h0);
        rd(A_ENV, v); chk_eq("R7 zero write keeps", v, 32'hC0);
    endtask

    task automatic t_access();
        logic [31:0] v;
        logic [31:0] p0;
        rd(A_SET, v); chk_eq("R8 set reg reads 0", v, 32'h0);
        rd(A_CLR, v); chk_eq("R8 clear reg reads 0", v, 32'h0);
        rd(A_CMD, v); chk_eq("R8 command reads 0", v, 32'h0);
        rd(12'h040, v); chk_eq("R8 unmapped reads 0", v, 32'h0);
        wr(A_ENV, 32'hFFFF_FFFF);
        rd(A_ENV, v); chk_eq("R8 enable view write ignored", v, 32'hC0);
        rd(A_PND, p0);
        wr(A_PND, ~p0);
        rd(A_PND, v); chk_eq("R8 pending view write ignored", v, p0);
    endtask

    task automatic t_output();
        wr(A_TRIG, 32'h0);
        wr(A_DUAL, 32'h0);
        wr(A_POL, 32'hFFFF_FFFF);
        wr(A_CLR, 32'hFFFF_FFFF);
        irq_in = 32'h0000_0300;
        wait_n(4);
        chk_eq("R9 masked out", irq_out, 32'h0);
        chk_eq("R9 masked any", {31'b0, irq_any}, 32'h0);
        wr(A_SET, 32'h0000_0100);
        chk_eq("R9 enabled out", irq_out, 32'h100);
        chk_eq("R9 enabled any", {31'b0, irq_any}, 32'h1);
        wr(A_CLR, 32'h0000_0100);
        chk_eq("R9 disabled again", irq_out, 32'h0);
        chk_eq("R9 any drops", {31'b0, irq_any}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_level();
        t_edge();
        t_dual();
        t_cmd();
        t_enable();
        t_access();
        t_output();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule